// File: doc/BRIEF.md
# Mailbox Receive Queue

This block is the receiving half of an inter-processor mailbox. A remote agent delivers 64-bit messages, each carrying a 3-bit source channel number. The block keeps them in a circular queue of `DEPTH` entries. The local processor sees only the oldest entry, through three read registers: the channel number, the low word and the high word. It writes a trigger register to discard that entry and bring the next one forward.

Software works out how many entries are waiting from the raw read and write indices in the status register. When the two indices are equal, a separate full bit tells a full queue from an empty one. A read-only register reports the capacity minus one. A pending flag is set while any entry is waiting, and a mask bit gates that flag onto the interrupt output.

Top module: `mbox_rx_fifo`

## Requirements
- R1: After reset the read index, write index, full bit and pending flag are 0. The mask register (offset 0x1C, 5 bits) reads 0x1F. The depth register (offset 0x24) reads DEPTH-1.
- R2: For the oldest waiting entry, offset 0x00 returns the channel number in bits [2:0], offset 0x04 returns message bits [31:0] and offset 0x08 returns message bits [63:32].
- R3: The status register (offset 0x14) holds the full bit in bit 0, the write index in [23:16] and the read index in [31:24]. The full bit is set only when the indices are equal and DEPTH entries are waiting.
- R4: An accepted push stores the entry at the write index and advances that index, wrapping from DEPTH-1 to 0. A push that makes the indices equal sets the full bit.
- R5: Writing a value with bit 0 set to offset 0x0C pops the oldest entry. The read index advances and wraps, and the full bit clears. A pop while empty leaves both indices unchanged.
- R6: A push while full is dropped, even when a pop happens in the same cycle.
- R7: A push and a pop in the same cycle on a queue that is neither empty nor full both take effect, and the occupancy is unchanged.
- R8: Writing offset 0x10 with bit 0 clear empties the queue: both indices go to 0 and the full bit and pending flag clear. Writing it with bit 0 set has no effect.
- R9: The pending flag (offset 0x18, bit 0) is set on every cycle that the queue is non-empty. Writing offset 0x18 with bit 0 set clears it. If entries remain, it sets again on the following cycle.
- R10: The interrupt output equals the pending flag while mask bit 0 is clear, and is 0 while mask bit 0 is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| pushValid | input | 1 | Remote side offers an entry this cycle |
| pushId | input | 3 | Source channel of the offered entry |
| pushMsg | input | 64 | Message payload of the offered entry |
| regWe | input | 1 | Register write strobe |
| regAddr | input | 6 | Register byte offset |
| regWdata | input | 32 | Register write data |
| regRdata | output | 32 | Register read data, combinational from regAddr |
| irqOut | output | 1 | Not-empty interrupt |

## Verification
The assertions check on every cycle that the full bit only appears with equal indices, that pushes while full and pops while empty leave the indices alone, that the write index wraps correctly, and that a waiting entry keeps the pending flag set and a set mask bit keeps the interrupt low. Only the bench scenarios can show that the correct payload and channel reach the head registers in arrival order. The same is true of the occupancy that software derives from the status fields across wrap-around, the flush and its ignored variant, and the one-cycle gap before the pending flag sets again. A long pseudo-random mix of pushes and pops, compared against an arithmetic queue model, covers these.

// File: rtl/mbox_rx_pkg.sv
package mbox_rx_pkg;
  localparam int ADDR_W = 6;
  localparam logic [ADDR_W-1:0] OFS_ID    = 6'h00;
  localparam logic [ADDR_W-1:0] OFS_LO    = 6'h04;
  localparam logic [ADDR_W-1:0] OFS_HI    = 6'h08;
  localparam logic [ADDR_W-1:0] OFS_TRIG  = 6'h0C;
  localparam logic [ADDR_W-1:0] OFS_FLUSH = 6'h10;
  localparam logic [ADDR_W-1:0] OFS_STAT  = 6'h14;
  localparam logic [ADDR_W-1:0] OFS_PEND  = 6'h18;
  localparam logic [ADDR_W-1:0] OFS_MASK  = 6'h1C;
  localparam logic [ADDR_W-1:0] OFS_DEPTH = 6'h24;
  localparam int ID_W   = 3;
  localparam int MSG_W  = 64;
  localparam int MASK_W = 5;

  typedef struct packed {
    logic push;
    logic pop;
    logic flush;
  } fifoStrb_t;
endpackage

// File: rtl/mbox_rx_ctrl.sv
module mbox_rx_ctrl
  import mbox_rx_pkg::*;
(
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  pushValid,
  input  logic                  regWe,
  input  logic [ADDR_W-1:0]     regAddr,
  input  logic [31:0]           regWdata,
  input  logic                  fifoEmpty,
  input  logic                  fifoFull,
  output fifoStrb_t             strb,
  output logic                  pendingQ,
  output logic [MASK_W-1:0]     maskQ
);
  logic trigWr, flushWr, clrWr, maskWr;

  always_comb begin
    trigWr  = regWe && (regAddr == OFS_TRIG)  && regWdata[0];
    flushWr = regWe && (regAddr == OFS_FLUSH) && !regWdata[0];
    clrWr   = regWe && (regAddr == OFS_PEND)  && regWdata[0];
    maskWr  = regWe && (regAddr == OFS_MASK);
    strb.flush = flushWr;
    strb.pop   = trigWr && !fifoEmpty && !flushWr;
    strb.push  = pushValid && !fifoFull && !flushWr;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pendingQ <= 1'b0;
      maskQ    <= '1;
    end else begin
      if (clrWr || flushWr) pendingQ <= 1'b0;
      else if (!fifoEmpty)  pendingQ <= 1'b1;
      if (maskWr) maskQ <= regWdata[MASK_W-1:0];
    end
  end
endmodule

// File: rtl/mbox_rx_dpath.sv
module mbox_rx_dpath
  import mbox_rx_pkg::*;
#(
  parameter int DEPTH = 8,
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1
)(
  input  logic             clk,
  input  logic             rstN,
  input  fifoStrb_t        strb,
  input  logic [ID_W-1:0]  pushId,
  input  logic [MSG_W-1:0] pushMsg,
  output logic [ID_W-1:0]  headId,
  output logic [MSG_W-1:0] headMsg,
  output logic [AW-1:0]    rdPtr,
  output logic [AW-1:0]    wrPtr,
  output logic             fullFlag,
  output logic             fifoEmpty
);
  localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);

  logic [ID_W+MSG_W-1:0] store [DEPTH];
  logic [AW-1:0] wrNext, rdNext;

  always_comb begin
    wrNext    = (wrPtr == LAST) ? '0 : wrPtr + 1'b1;
    rdNext    = (rdPtr == LAST) ? '0 : rdPtr + 1'b1;
    fifoEmpty = (wrPtr == rdPtr) && !fullFlag;
    {headId, headMsg} = store[rdPtr];
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rdPtr    <= '0;
      wrPtr    <= '0;
      fullFlag <= 1'b0;
    end else if (strb.flush) begin
      rdPtr    <= '0;
      wrPtr    <= '0;
      fullFlag <= 1'b0;
    end else begin
      if (strb.push) wrPtr <= wrNext;
      if (strb.pop)  rdPtr <= rdNext;
      if (strb.pop)  fullFlag <= 1'b0;
      else if (strb.push && (wrNext == rdPtr)) fullFlag <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (strb.push) store[wrPtr] <= {pushId, pushMsg};
  end
endmodule

// File: rtl/mbox_rx_fifo.sv
module mbox_rx_fifo
  import mbox_rx_pkg::*;
#(
  parameter int DEPTH = 8,
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1
)(
  input  logic        clk,
  input  logic        rstN,
  input  logic        pushValid,
  input  logic [2:0]  pushId,
  input  logic [63:0] pushMsg,
  input  logic        regWe,
  input  logic [5:0]  regAddr,
  input  logic [31:0] regWdata,
  output logic [31:0] regRdata,
  output logic        irqOut
);
  fifoStrb_t         strb;
  logic [ID_W-1:0]   headId;
  logic [MSG_W-1:0]  headMsg;
  logic [AW-1:0]     rdPtr, wrPtr;
  logic              fullFlag, fifoEmpty, pendingQ;
  logic [MASK_W-1:0] maskQ;

  mbox_rx_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .pushValid(pushValid), .regWe(regWe),
    .regAddr(regAddr), .regWdata(regWdata), .fifoEmpty(fifoEmpty),
    .fifoFull(fullFlag), .strb(strb), .pendingQ(pendingQ), .maskQ(maskQ)
  );

  mbox_rx_dpath #(.DEPTH(DEPTH)) u_dpath (
    .clk(clk), .rstN(rstN), .strb(strb), .pushId(pushId), .pushMsg(pushMsg),
    .headId(headId), .headMsg(headMsg), .rdPtr(rdPtr), .wrPtr(wrPtr),
    .fullFlag(fullFlag), .fifoEmpty(fifoEmpty)
  );

  assign irqOut = pendingQ && !maskQ[0];

  always_comb begin
    regRdata = '0;
    case (regAddr)
      OFS_ID:    regRdata[ID_W-1:0] = headId;
      OFS_LO:    regRdata = headMsg[31:0];
      OFS_HI:    regRdata = headMsg[63:32];
      OFS_STAT:  begin
        regRdata[0]     = fullFlag;
        regRdata[23:16] = 8'(wrPtr);
        regRdata[31:24] = 8'(rdPtr);
      end
      OFS_PEND:  regRdata[0] = pendingQ;
      OFS_MASK:  regRdata[MASK_W-1:0] = maskQ;
      OFS_DEPTH: regRdata = 32'(DEPTH - 1);
      default:   regRdata = '0;
    endcase
  end
endmodule

// File: rtl/mbox_rx_fifo_chk.sv
module mbox_rx_fifo_chk #(
  parameter int DEPTH = 8,
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1
)(
  input logic          clk,
  input logic          rstN,
  input logic          pushValid,
  input logic          regWe,
  input logic [5:0]    regAddr,
  input logic [31:0]   regWdata,
  input logic          irqOut,
  input logic [AW-1:0] rdPtr,
  input logic [AW-1:0] wrPtr,
  input logic          fullFlag,
  input logic          pendingQ,
  input logic [4:0]    maskQ
);
  logic isEmpty, flushing, clearing, popping;
  assign isEmpty  = (rdPtr == wrPtr) && !fullFlag;
  assign flushing = regWe && regAddr == 6'h10 && regWdata[0] == 1'b0;
  assign clearing = regWe && regAddr == 6'h18 && regWdata[0] == 1'b1;
  assign popping  = regWe && regAddr == 6'h0C && regWdata[0] == 1'b1;

  function automatic logic [AW-1:0] stepIdx(input logic [AW-1:0] p);
    return (32'(p) == DEPTH - 1) ? '0 : p + 1'b1;
  endfunction

  a_r3_full_equal: assert property (@(posedge clk) disable iff (!rstN)
    fullFlag |-> rdPtr == wrPtr);
  a_r6_drop_when_full: assert property (@(posedge clk) disable iff (!rstN)
    (fullFlag && pushValid && !flushing) |=> $stable(wrPtr));
  a_r5_empty_pop_ignored: assert property (@(posedge clk) disable iff (!rstN)
    (isEmpty && popping && !flushing) |=> $stable(rdPtr));
  a_r4_write_wrap: assert property (@(posedge clk) disable iff (!rstN)
    (pushValid && !fullFlag && !flushing) |=> wrPtr == stepIdx($past(wrPtr)));
  a_r9_pending_sets: assert property (@(posedge clk) disable iff (!rstN)
    (!isEmpty && !clearing && !flushing) |=> pendingQ);
  a_r10_masked: assert property (@(posedge clk) disable iff (!rstN)
    maskQ[0] |-> !irqOut);
endmodule

bind mbox_rx_fifo mbox_rx_fifo_chk #(.DEPTH(DEPTH)) u_chk (
  .clk(clk), .rstN(rstN), .pushValid(pushValid), .regWe(regWe),
  .regAddr(regAddr), .regWdata(regWdata), .irqOut(irqOut),
  .rdPtr(rdPtr), .wrPtr(wrPtr), .fullFlag(fullFlag),
  .pendingQ(pendingQ), .maskQ(maskQ)
);

// File: tb/mbox_rx_fifo_tb.sv
module mbox_rx_fifo_tb;
  localparam int DEPTH = 8;
  logic clk = 0, rstN = 0;
  logic pushValid = 0, regWe = 0;
  logic [2:0] pushId = 0;
  logic [63:0] pushMsg = 0;
  logic [5:0] regAddr = 0;
  logic [31:0] regWdata = 0, regRdata;
  logic irqOut;
  int nChk = 0, nBad = 0, mRd = 0, mWr = 0, msgN = 0;
  bit done = 0;
  logic [66:0] q[$];

  always #2.5 clk = ~clk;

  mbox_rx_fifo #(.DEPTH(DEPTH)) u_dut (.*);

  task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
    nChk++;
    if (got !== exp) begin
      nBad++;
      $display("FAIL %s actual=%h expected=%h", tag, got, exp);
    end
  endtask

  task automatic rd(input logic [5:0] a, output logic [31:0] v);
    regAddr = a; #1; v = regRdata;
  endtask

  task automatic wr(input logic [5:0] a, input logic [31:0] d);
    @(negedge clk); regAddr = a; regWe = 1; regWdata = d;
    @(negedge clk); regWe = 0;
  endtask

  task automatic step(input bit doPush, input bit doPop);
    logic [66:0] e;
    bit popOk, pushOk;
    msgN++;
    e = {3'(msgN % 8), 32'hC000_0000 ^ 32'(msgN * 7919), 32'h1000_0000 + 32'(msgN)};
    @(negedge clk);
    pushValid = doPush; {pushId, pushMsg} = e;
    regWe = doPop; regAddr = 6'h0C; regWdata = 1;
    @(negedge clk);
    pushValid = 0; regWe = 0;
    popOk = doPop && q.size() > 0;
    pushOk = doPush && q.size() < DEPTH;
    if (popOk) begin void'(q.pop_front()); mRd = (mRd + 1) % DEPTH; end
    if (pushOk) begin q.push_back(e); mWr = (mWr + 1) % DEPTH; end
  endtask

  task automatic checkAll(input string tag);
    logic [31:0] s, v;
    int w, r, occ;
    rd(6'h14, s);
    w = int'(s[23:16]); r = int'(s[31:24]);
    check({tag, " R3 full"}, {31'd0, s[0]}, {31'd0, q.size() == DEPTH});
    check({tag, " R4 wr"}, 32'(w), 32'(mWr));
    check({tag, " R5 rd"}, 32'(r), 32'(mRd));
    if (w == r) occ = s[0] ? DEPTH : 0;
    else if (w > r) occ = w - r;
    else occ = DEPTH - r + w;
    check({tag, " R3 occupancy"}, 32'(occ), 32'(q.size()));
    if (q.size() > 0) begin
      rd(6'h00, v); check({tag, " R2 id"}, v, {29'd0, q[0][66:64]});
      rd(6'h04, v); check({tag, " R2 lo"}, v, q[0][31:0]);
      rd(6'h08, v); check({tag, " R2 hi"}, v, q[0][63:32]);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      nBad++; nChk++;
      $display("FAIL watchdog expired");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChk, nBad);
      $finish;
    end
  end

  initial begin
    logic [31:0] v;
    logic [15:0] lfsr = 16'hACE1;
    repeat (3) @(negedge clk);
    rstN = 1;
    @(negedge clk);
    // R1 reset state
    rd(6'h14, v); check("R1 status", v, 0);
    rd(6'h1C, v); check("R1 mask", v, 32'h1F);
    rd(6'h24, v); check("R1 depth", v, DEPTH - 1);
    rd(6'h18, v); check("R1 pending", v, 0);
    check("R1 irq", {31'd0, irqOut}, 0);

    wr(6'h1C, 32'h1E);
    for (int i = 0; i < 3; i++) step(1, 0);
    checkAll("R4 three pushes");
    @(negedge clk);
    check("R9 pending set", {31'd0, irqOut}, 1);
    wr(6'h18, 1);
    check("R9 cleared", {31'd0, irqOut}, 0);
    @(negedge clk);
    check("R9 reasserts", {31'd0, irqOut}, 1);
    wr(6'h1C, 32'h1F);
    rd(6'h18, v); check("R10 pending still", v, 1);
    check("R10 masked", {31'd0, irqOut}, 0);
    wr(6'h1C, 32'h1E);

    step(0, 1); checkAll("R5 pop");
    while (q.size() < DEPTH) step(1, 0);
    checkAll("R4 filled");
    step(1, 0); checkAll("R6 push full");
    step(1, 1); checkAll("R6 push+pop full");
    step(1, 1); checkAll("R7 push+pop");
    while (q.size() > 0) step(0, 1);
    checkAll("R5 drained");
    step(0, 1); checkAll("R5 pop empty");
    wr(6'h18, 1); @(negedge clk);
    check("R9 empty stays clear", {31'd0, irqOut}, 0);

    step(1, 0); step(1, 0);
    wr(6'h10, 1); checkAll("R8 ignored flush");
    wr(6'h10, 0);
    q.delete(); mRd = 0; mWr = 0;
    checkAll("R8 flush");
    rd(6'h18, v); check("R8 pending cleared", v, 0);

    for (int i = 0; i < 400; i++) begin
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      step(lfsr[0] | (lfsr[3] & lfsr[5]), lfsr[1]);
      checkAll("R7 sweep");
    end

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChk, nBad);
    $finish;
  end
endmodule